// File: doc/BRIEF.md
# Request-Driven Queue Transfer Channel

This block is one DMA channel that sits between a peripheral's FIFO register and a queue held in system memory. Every request from the peripheral moves exactly one element. Nothing is ever moved as a burst. In command mode the channel reads a 32-bit word from a queue address that steps forward. It then writes that word to a fixed peripheral push address. In result mode it reads a 16-bit item from a fixed peripheral pop address. It then writes that item to a queue address that steps forward.

A programmable element count defines the queue length. When the last element has moved, the channel takes the end action that was configured. The first choice is to switch itself off and raise a done flag, which suits a single pass over the queue. The second choice is to reload the stepping pointer and the counter from the configured queue start, which suits continuous cyclic scanning. Software programs the channel through a small write port. The memory side is a single request/ready handshake, and the peripheral sees a one-cycle acknowledge for each element.

Top module: `qxfer_chan`

## Requirements
- R1: Each request pulse on `perReq` seen while the channel is enabled causes exactly one memory read, then exactly one memory write, then one `perAck` pulse.
- R2: In command mode (control bit 1 = 0), the read goes to the stepping pointer and the write goes to the fixed peripheral address. The full 32-bit read word is written, and `memHalf` is 0.
- R3: In command mode the stepping pointer grows by 4 after each completed element.
- R4: In result mode (control bit 1 = 1), the read goes to the fixed peripheral address and the write goes to the stepping pointer. The written data is the low 16 bits of the read word with the upper 16 bits zero, and `memHalf` is 1.
- R5: In result mode the stepping pointer grows by 2 after each completed element.
- R6: With end action "stop" (control bit 2 = 0), the channel handles its last element as follows. As it finishes, `chanEnabled` falls and `chanDone` rises, and both are visible in the cycle of that element's `perAck`.
- R7: With end action "reload" (control bit 2 = 1), after the last element the pointer returns to the queue start and the count returns to the programmed length. `chanDone` stays 0.
- R8: While the channel is disabled, a request causes no memory access and no `perAck`.
- R9: `perAck` is a single-cycle pulse. It rises only in the cycle after the element's write handshake (`memReq`, `memWe` and `memRdy` all high).
- R10: A request that arrives while a transfer is still in progress is held pending. It is served right after the current element finishes.
- R11: The configuration registers are selected by `cfgAddr`: 0 is control (bit 0 enable, bit 1 mode, bit 2 end action), 1 is queue start, 2 is peripheral address, and 3 is queue length. Writing control with bit 0 = 1 loads the pointer from the queue start and the count from the length, and it clears `chanDone`.
- R12: After reset, `memReq`, `perAck`, `chanEnabled` and `chanDone` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWdata | input | ADDR_W | Configuration write data |
| perReq | input | 1 | Peripheral transfer request pulse |
| perAck | output | 1 | One-cycle acknowledge per element moved |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memHalf | output | 1 | 1 = 16-bit access, 0 = 32-bit access |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid while memRdy is high on a read |
| memRdy | input | 1 | Memory completes the current access this cycle |
| chanEnabled | output | 1 | Channel is enabled |
| chanDone | output | 1 | Channel stopped at the end of its queue |

## Verification
Some rules are checked by assertions on every cycle. An acknowledge only follows a write handshake and never lasts two cycles. No memory access happens while the channel is off. The pointer holds still unless the control issues a step or a load. A set done flag implies the channel is off. Other behaviour can only be shown by the bench's scenarios. These are the exact addresses and data of every element, the 4-byte and 2-byte strides, the wrap back to the queue start and the stop at the end of the queue. The bench sweeps both modes, both end actions and queue lengths 1 to 4, with and without memory stalls. It also covers the servicing of a request that arrives while a transfer is in progress.

// File: rtl/qxfer_pkg.sv
package qxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2,
    ST_ACK = 2'd3
  } xferState_t;

  typedef struct packed {
    logic readPhase;
    logic capture;
    logic step;
    logic load;
  } dpStrb_t;

  localparam logic [1:0] CFG_CTRL  = 2'd0;
  localparam logic [1:0] CFG_START = 2'd1;
  localparam logic [1:0] CFG_PERIPH = 2'd2;
  localparam logic [1:0] CFG_LEN   = 2'd3;
endpackage

// File: rtl/qxfer_dp.sv
module qxfer_dp
  import qxfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  dpStrb_t           strb,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              memHalf,
  output logic              endReload,
  output logic              lastElem
);
  localparam logic [ADDR_W-1:0] STEP_CMD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_RES = ADDR_W'(2);

  logic              modeResult;
  logic [ADDR_W-1:0] queueStart;
  logic [ADDR_W-1:0] periphAddr;
  logic [LEN_W-1:0]  queueLen;
  logic [ADDR_W-1:0] ptr;
  logic [LEN_W-1:0]  remain;
  logic [31:0]       holdBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeResult <= 1'b0;
      endReload  <= 1'b0;
      queueStart <= '0;
      periphAddr <= '0;
      queueLen   <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        CFG_CTRL: begin
          modeResult <= cfgWdata[1];
          endReload  <= cfgWdata[2];
        end
        CFG_START:  queueStart <= cfgWdata;
        CFG_PERIPH: periphAddr <= cfgWdata;
        default:    queueLen <= cfgWdata[LEN_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      remain  <= '0;
      holdBuf <= '0;
    end else begin
      if (strb.load) begin
        ptr    <= queueStart;
        remain <= queueLen;
      end else if (strb.step) begin
        ptr    <= ptr + (modeResult ? STEP_RES : STEP_CMD);
        remain <= remain - 1'b1;
      end
      if (strb.capture) holdBuf <= memRdata;
    end
  end

  always_comb begin
    if (strb.readPhase) memAddr = modeResult ? periphAddr : ptr;
    else                memAddr = modeResult ? ptr : periphAddr;
    memWdata = modeResult ? {16'h0000, holdBuf[15:0]} : holdBuf;
    memHalf  = modeResult;
    lastElem = (remain == LEN_W'(1));
  end

  assert_ptr_hold_R3 : assert property (@(posedge clk) disable iff (!rstN)
    !(strb.step || strb.load) |=> $stable(ptr));
  assert_count_hold_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !(strb.step || strb.load) |=> $stable(remain));
endmodule

// File: rtl/qxfer_ctrl.sv
module qxfer_ctrl
  import qxfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              perReq,
  input  logic              memRdy,
  input  logic              endReload,
  input  logic              lastElem,
  output dpStrb_t           strb,
  output logic              perAck,
  output logic              memReq,
  output logic              memWe,
  output logic              chanEnabled,
  output logic              chanDone
);
  xferState_t state, stateNext;
  logic pending, pendingNext;
  logic enableNext, doneNext;
  logic ctrlWrite, writeDone;

  always_comb begin
    ctrlWrite = cfgWe && (cfgAddr == CFG_CTRL);
    writeDone = (state == ST_WRITE) && memRdy;
    strb = '0;
    strb.readPhase = (state == ST_READ);
    strb.capture = (state == ST_READ) && memRdy;
    enableNext = chanEnabled;
    doneNext = chanDone;
    if (writeDone) begin
      if (lastElem && endReload) strb.load = 1'b1;
      else strb.step = 1'b1;
      if (lastElem && !endReload) begin
        enableNext = 1'b0;
        doneNext = 1'b1;
      end
    end
    if (ctrlWrite) begin
      enableNext = cfgWdata[0];
      if (cfgWdata[0]) begin
        strb.load = 1'b1;
        strb.step = 1'b0;
        doneNext = 1'b0;
      end
    end

    stateNext = state;
    case (state)
      ST_IDLE:  if (chanEnabled && pending) stateNext = ST_READ;
      ST_READ:  if (memRdy) stateNext = ST_WRITE;
      ST_WRITE: if (memRdy) stateNext = ST_ACK;
      default:  stateNext = ST_IDLE;
    endcase
    if (!enableNext && state != ST_WRITE && state != ST_ACK) stateNext = ST_IDLE;
    if (ctrlWrite && !cfgWdata[0] && state == ST_WRITE) stateNext = ST_IDLE;

    pendingNext = enableNext &&
      (perReq || (pending && !(state == ST_IDLE && chanEnabled)));

    memReq = (state == ST_READ) || (state == ST_WRITE);
    memWe = (state == ST_WRITE);
    perAck = (state == ST_ACK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      pending     <= 1'b0;
      chanEnabled <= 1'b0;
      chanDone    <= 1'b0;
    end else begin
      state       <= stateNext;
      pending     <= pendingNext;
      chanEnabled <= enableNext;
      chanDone    <= doneNext;
    end
  end

  assert_ack_after_write_R9 : assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> $past(memReq && memWe && memRdy));
  assert_ack_pulse_R9 : assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck);
  assert_no_access_disabled_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> chanEnabled);
  assert_done_stops_R6 : assert property (@(posedge clk) disable iff (!rstN)
    chanDone |-> !chanEnabled);
endmodule

// File: rtl/qxfer_chan.sv
module qxfer_chan
  import qxfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              perReq,
  output logic              perAck,
  output logic              memReq,
  output logic              memWe,
  output logic              memHalf,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memRdy,
  output logic              chanEnabled,
  output logic              chanDone
);
  dpStrb_t strb;
  logic endReload;
  logic lastElem;

  qxfer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .perReq(perReq), .memRdy(memRdy),
    .endReload(endReload), .lastElem(lastElem), .strb(strb),
    .perAck(perAck), .memReq(memReq), .memWe(memWe),
    .chanEnabled(chanEnabled), .chanDone(chanDone)
  );

  qxfer_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .strb(strb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memHalf(memHalf),
    .endReload(endReload), .lastElem(lastElem)
  );
endmodule

// File: tb/qxfer_chan_tb.sv
module qxfer_chan_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic perReq = 1'b0;
  logic perAck, memReq, memWe, memHalf, chanEnabled, chanDone;
  logic [31:0] memAddr, memWdata, memRdata;
  logic memRdy;
  logic stall = 1'b0;
  logic tog = 1'b0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tog <= ~tog;

  function automatic logic [31:0] rdFunc(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1111};
  endfunction

  assign memRdy = !stall || tog;
  assign memRdata = rdFunc(memAddr);

  qxfer_chan u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .perReq(perReq), .perAck(perAck),
    .memReq(memReq), .memWe(memWe), .memHalf(memHalf),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memRdy(memRdy), .chanEnabled(chanEnabled), .chanDone(chanDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk);
    perReq = 1'b1;
    @(negedge clk);
    perReq = 1'b0;
  endtask

  // one element: request, then watch handshakes until the acknowledge
  task automatic doXfer(input logic [31:0] expRd, input logic [31:0] expWr,
                        input logic [31:0] expData, input logic expHalf);
    int reads = 0;
    int writes = 0;
    logic [31:0] rdA = '0, wrA = '0, wrD = '0;
    logic halfSeen = 1'b0;
    logic acked = 1'b0;
    logic wrBeforeAck = 1'b0;
    pulseReq();
    for (int k = 0; k < 40 && !acked; k++) begin
      if (memReq && memRdy && !memWe) begin reads++; rdA = memAddr; halfSeen = memHalf; end
      if (memReq && memRdy && memWe) begin writes++; wrA = memAddr; wrD = memWdata; end
      if (perAck) begin acked = 1'b1; wrBeforeAck = (writes == 1); end
      else @(negedge clk);
    end
    check("R1 ack seen", 32'(acked), 32'd1);
    check("R1 one read", 32'(reads), 32'd1);
    check("R1 one write", 32'(writes), 32'd1);
    check("R9 write before ack", 32'(wrBeforeAck), 32'd1);
    check(expHalf ? "R4 read addr" : "R2 read addr", rdA, expRd);
    check(expHalf ? "R4 write addr" : "R2 write addr", wrA, expWr);
    check(expHalf ? "R4 write data" : "R2 write data", wrD, expData);
    check(expHalf ? "R4 half" : "R2 half", 32'(halfSeen), 32'(expHalf));
    @(negedge clk);
    check("R9 ack one cycle", 32'(perAck), 32'd0);
  endtask

  task automatic expectIgnored(input string req);
    int acts = 0;
    pulseReq();
    for (int k = 0; k < 12; k++) begin
      if (memReq || perAck) acts++;
      @(negedge clk);
    end
    check(req, 32'(acts), 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R12 memReq", 32'(memReq), 32'd0);
    check("R12 perAck", 32'(perAck), 32'd0);
    check("R12 enabled", 32'(chanEnabled), 32'd0);
    check("R12 done", 32'(chanDone), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    expectIgnored("R8 ignored before enable");

    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int len = 1; len <= 4; len++) begin
          logic [31:0] qs, pa;
          int n;
          qs = 32'h1000 + 32'(m) * 32'h100 + 32'(len) * 32'h20;
          pa = 32'h40 + 32'(m) * 4;
          stall = (len % 2) == 0;
          cfgWrite(2'd1, qs);
          cfgWrite(2'd2, pa);
          cfgWrite(2'd3, 32'(len));
          cfgWrite(2'd0, 32'(1 | (m << 1) | (e << 2)));
          check("R11 done cleared", 32'(chanDone), 32'd0);
          check("R11 enabled", 32'(chanEnabled), 32'd1);
          n = (e != 0) ? 2 * len + 1 : len;
          for (int i = 0; i < n; i++) begin
            int idx;
            logic [31:0] p;
            idx = (e != 0) ? (i % len) : i;
            // R3 stride 4 in command mode, R5 stride 2 in result mode
            p = qs + 32'(idx) * ((m != 0) ? 32'd2 : 32'd4);
            if (m == 0) doXfer(p, pa, rdFunc(p), 1'b0);
            else doXfer(pa, p, {16'h0, rdFunc(pa)[15:0]}, 1'b1);
          end
          if (e == 0) begin
            check("R6 done set", 32'(chanDone), 32'd1);
            check("R6 disabled", 32'(chanEnabled), 32'd0);
            expectIgnored("R8 ignored after stop");
          end else begin
            check("R7 done stays low", 32'(chanDone), 32'd0);
            check("R7 still enabled", 32'(chanEnabled), 32'd1);
          end
        end
      end
    end

    // R10: second request while the first transfer is still running
    begin
      int acks = 0;
      int reads = 0;
      logic [31:0] rdAddr [2];
      stall = 1'b1;
      cfgWrite(2'd1, 32'h2000);
      cfgWrite(2'd2, 32'h80);
      cfgWrite(2'd3, 32'd4);
      cfgWrite(2'd0, 32'h5);
      fork
        begin
          pulseReq();
          @(negedge clk);
          pulseReq();
        end
        begin
          for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (memReq && memRdy && !memWe) begin
              if (reads < 2) rdAddr[reads] = memAddr;
              reads++;
            end
            if (perAck) acks++;
          end
        end
      join
      check("R10 two acks", 32'(acks), 32'd2);
      check("R10 two reads", 32'(reads), 32'd2);
      check("R10 first addr", rdAddr[0], 32'h2000);
      check("R10 second addr", rdAddr[1], 32'h2004);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule